// File: doc/BRIEF.md
# Spare DIMM Failover Controller

This controller keeps a running error tally for every DIMM in a two-channel memory system and holds one shared limit that all tallies are measured against. When any tally rises above that limit, the controller asks an external copy engine to move the failing DIMM's contents, and then its counterpart in the other channel, onto the reserved spare. Only when both copies are done does it put the spare into service and mark the two original DIMMs as retired. The address decoder uses the remap outputs, and the copy data path sits outside the block.

A limit of zero turns the feature off. In that case the spare is reported as ordinary visible memory, and no failover can start. The failover happens at most once. After the spare is in service, the controller ignores every later error event and every change to the limit.

Top module: `dimm_spare_ctrl`

## Requirements
- R1: After reset the state output reads IDLE (code 0), no copy request is raised, `spareInService` is 0, `retireMask` is all zero and `failDimm` is 0.
- R2: While `threshold` is zero and no failover has begun, the state reads DISABLED (code 3) and `spareHidden` is 0. A non-zero threshold moves the state back to IDLE (code 0) with `spareHidden` at 1.
- R3: One cycle after a DIMM's tally becomes strictly greater than a non-zero threshold, the state reads COPYING (code 1). A tally equal to the threshold starts nothing.
- R4: In COPYING, `copyReq` is high and `copySrc` first names the failing DIMM. The request holds until `copyDone` is sampled high. `copySrc` then names the partner DIMM, which is the failing index XOR NUM_DIMMS/2.
- R5: A `copyDone` during the partner copy moves the state to SPARED (code 2). SPARED drops `copyReq`, sets `spareInService` to 1, and sets exactly the bits of the failing and partner DIMMs in `retireMask`.
- R6: SPARED is permanent until reset. Later error events and threshold changes leave the state, `retireMask` and `copyReq` unchanged.
- R7: If several tallies exceed the threshold in the same cycle, the lowest-numbered DIMM becomes the failing DIMM.
- R8: Each tally saturates at its maximum value (2^CNT_W-1) and does not wrap. Tallies keep counting while the feature is disabled.
- R9: `failDimm` reports the captured failing DIMM index throughout COPYING and SPARED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| errValid | input | 1 | One runtime error event this cycle |
| errDimm | input | IDX_W | DIMM index of the error event |
| threshold | input | CNT_W | Shared failover limit; zero disables |
| copyReq | output | 1 | Request to the copy engine |
| copySrc | output | IDX_W | DIMM whose contents are to be copied |
| copyDone | input | 1 | Copy engine finished the current request |
| spareInService | output | 1 | Accesses are redirected to the spare |
| spareHidden | output | 1 | Spare is held in reserve, out of the address map |
| retireMask | output | NUM_DIMMS | DIMMs removed from service |
| stateOut | output | 2 | 0 IDLE, 1 COPYING, 2 SPARED, 3 DISABLED |
| failDimm | output | IDX_W | Index of the DIMM that triggered failover |

## Verification
A miscounted tally or a wrong comparison shows up in `stateOut` one cycle after the offending error or threshold change: the state either enters COPYING too early or fails to enter it. A wrong captured index or a wrong partner computation appears on `copySrc` in the same cycle COPYING begins, or in the cycle after the first `copyDone`. A leak out of SPARED shows up on the next error event or threshold change as a new `copyReq` or a changed `retireMask`.

// File: rtl/dimm_spare_pkg.sv
package dimm_spare_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_COPYING  = 2'd1,
    ST_SPARED   = 2'd2,
    ST_DISABLED = 2'd3
  } spareState_t;

  typedef struct packed {
    logic captureFail;
    logic selectPartner;
    logic spared;
  } ctlStrobe_t;

endpackage

// File: rtl/dimm_spare_dp.sv
module dimm_spare_dp
  import dimm_spare_pkg::*;
#(
  parameter int NUM_DIMMS = 4,
  parameter int CNT_W     = 8,
  localparam int IDX_W    = $clog2(NUM_DIMMS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 errValid,
  input  logic [IDX_W-1:0]     errDimm,
  input  logic [CNT_W-1:0]     threshold,
  input  ctlStrobe_t           strb,
  output logic                 anyOver,
  output logic [IDX_W-1:0]     copySrc,
  output logic [IDX_W-1:0]     failDimm,
  output logic [NUM_DIMMS-1:0] retireMask
);

  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [IDX_W-1:0] PAIR_BIT = IDX_W'(NUM_DIMMS / 2);

  logic [NUM_DIMMS-1:0] overVec;
  logic [IDX_W-1:0]     lowIdx;
  logic [IDX_W-1:0]     failIdx;
  logic                 partnerSel;
  logic [IDX_W-1:0]     partnerIdx;

  for (genvar i = 0; i < NUM_DIMMS; i++) begin : gTally
    logic [CNT_W-1:0] tally;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tally <= '0;
      end else if (errValid && errDimm == IDX_W'(i) && tally != CNT_MAX) begin
        tally <= tally + 1'b1;
      end
    end
    assign overVec[i] = tally > threshold;
  end

  always_comb begin
    lowIdx = '0;
    for (int k = NUM_DIMMS - 1; k >= 0; k--) begin
      if (overVec[k]) lowIdx = IDX_W'(k);
    end
  end

  assign anyOver = |overVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failIdx    <= '0;
      partnerSel <= 1'b0;
    end else begin
      if (strb.captureFail) begin
        failIdx    <= lowIdx;
        partnerSel <= 1'b0;
      end
      if (strb.selectPartner) partnerSel <= 1'b1;
    end
  end

  assign partnerIdx = failIdx ^ PAIR_BIT;
  assign copySrc    = partnerSel ? partnerIdx : failIdx;
  assign failDimm   = failIdx;

  always_comb begin
    retireMask = '0;
    if (strb.spared) begin
      retireMask[failIdx]    = 1'b1;
      retireMask[partnerIdx] = 1'b1;
    end
  end

endmodule

// File: rtl/dimm_spare_fsm.sv
module dimm_spare_fsm
  import dimm_spare_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] threshold,
  input  logic             anyOver,
  input  logic             copyDone,
  output ctlStrobe_t       strb,
  output logic             copyReq,
  output logic             spareInService,
  output logic             spareHidden,
  output spareState_t      stateOut
);

  typedef enum logic [2:0] {
    F_IDLE, F_DISABLED, F_COPY_MAIN, F_COPY_PAIR, F_SPARED
  } fsm_t;

  fsm_t cur, nxt;
  logic enabled;

  assign enabled = threshold != '0;

  always_comb begin
    nxt               = cur;
    strb              = '0;
    strb.spared       = cur == F_SPARED;
    unique case (cur)
      F_IDLE: begin
        if (!enabled) begin
          nxt = F_DISABLED;
        end else if (anyOver) begin
          nxt              = F_COPY_MAIN;
          strb.captureFail = 1'b1;
        end
      end
      F_DISABLED:  if (enabled) nxt = F_IDLE;
      F_COPY_MAIN: begin
        if (copyDone) begin
          nxt                = F_COPY_PAIR;
          strb.selectPartner = 1'b1;
        end
      end
      F_COPY_PAIR: if (copyDone) nxt = F_SPARED;
      F_SPARED:    nxt = F_SPARED;
      default:     nxt = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cur <= F_IDLE;
    else       cur <= nxt;
  end

  always_comb begin
    unique case (cur)
      F_COPY_MAIN, F_COPY_PAIR: stateOut = ST_COPYING;
      F_SPARED:                 stateOut = ST_SPARED;
      F_DISABLED:               stateOut = ST_DISABLED;
      default:                  stateOut = ST_IDLE;
    endcase
  end

  assign copyReq        = cur == F_COPY_MAIN || cur == F_COPY_PAIR;
  assign spareInService = cur == F_SPARED;
  assign spareHidden    = cur == F_IDLE || copyReq;

endmodule

// File: rtl/dimm_spare_ctrl.sv
module dimm_spare_ctrl
  import dimm_spare_pkg::*;
#(
  parameter int NUM_DIMMS = 4,
  parameter int CNT_W     = 8,
  localparam int IDX_W    = $clog2(NUM_DIMMS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 errValid,
  input  logic [IDX_W-1:0]     errDimm,
  input  logic [CNT_W-1:0]     threshold,
  output logic                 copyReq,
  output logic [IDX_W-1:0]     copySrc,
  input  logic                 copyDone,
  output logic                 spareInService,
  output logic                 spareHidden,
  output logic [NUM_DIMMS-1:0] retireMask,
  output logic [1:0]           stateOut,
  output logic [IDX_W-1:0]     failDimm
);

  ctlStrobe_t  strb;
  logic        anyOver;
  spareState_t stateEnum;

  dimm_spare_dp #(.NUM_DIMMS(NUM_DIMMS), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .errValid(errValid), .errDimm(errDimm),
    .threshold(threshold), .strb(strb), .anyOver(anyOver),
    .copySrc(copySrc), .failDimm(failDimm), .retireMask(retireMask)
  );

  dimm_spare_fsm #(.CNT_W(CNT_W)) uFsm (
    .clk(clk), .rstN(rstN), .threshold(threshold), .anyOver(anyOver),
    .copyDone(copyDone), .strb(strb), .copyReq(copyReq),
    .spareInService(spareInService), .spareHidden(spareHidden),
    .stateOut(stateEnum)
  );

  assign stateOut = stateEnum;

endmodule

// File: rtl/dimm_spare_chk.sv
module dimm_spare_chk #(
  parameter int NUM_DIMMS = 4,
  parameter int CNT_W     = 8,
  localparam int IDX_W    = $clog2(NUM_DIMMS)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [CNT_W-1:0]     threshold,
  input logic                 copyReq,
  input logic [IDX_W-1:0]     copySrc,
  input logic                 copyDone,
  input logic                 spareInService,
  input logic [NUM_DIMMS-1:0] retireMask,
  input logic [1:0]           stateOut
);

  assert_start_needs_limit_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(copyReq) |-> $past(threshold) != '0);

  assert_src_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    (copyReq && !copyDone) |=> $stable(copySrc));

  assert_switch_after_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spareInService) |-> $past(copyDone));

  assert_retire_pair_R5: assert property (@(posedge clk) disable iff (!rstN)
    spareInService |-> $countones(retireMask) == 2);

  assert_spared_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    stateOut == 2'd2 |=> stateOut == 2'd2 && $stable(retireMask));

  assert_no_request_when_spared_R6: assert property (@(posedge clk) disable iff (!rstN)
    stateOut == 2'd2 |-> !copyReq);

endmodule

bind dimm_spare_ctrl dimm_spare_chk #(.NUM_DIMMS(NUM_DIMMS), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .threshold(threshold), .copyReq(copyReq),
  .copySrc(copySrc), .copyDone(copyDone), .spareInService(spareInService),
  .retireMask(retireMask), .stateOut(stateOut)
);

// File: tb/tb_dimm_spare_ctrl.sv
`timescale 1ns/1ps
module tb_dimm_spare_ctrl;

  localparam int NUM_DIMMS = 4;
  localparam int CNT_W     = 8;
  localparam int IDX_W     = 2;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 errValid = 1'b0;
  logic [IDX_W-1:0]     errDimm = '0;
  logic [CNT_W-1:0]     threshold = 8'd5;
  logic                 copyDone = 1'b0;
  logic                 copyReq, spareInService, spareHidden;
  logic [IDX_W-1:0]     copySrc, failDimm;
  logic [NUM_DIMMS-1:0] retireMask;
  logic [1:0]           stateOut;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  dimm_spare_ctrl #(.NUM_DIMMS(NUM_DIMMS), .CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .errValid(errValid), .errDimm(errDimm),
    .threshold(threshold), .copyReq(copyReq), .copySrc(copySrc),
    .copyDone(copyDone), .spareInService(spareInService),
    .spareHidden(spareHidden), .retireMask(retireMask),
    .stateOut(stateOut), .failDimm(failDimm)
  );

  // step table: threshold, error DIMM, error count, expected state, expected fail index
  localparam int NV = 7;
  localparam int vThr [NV]  = '{0, 5, 5, 5, 0, 6, 6};
  localparam int vDimm [NV] = '{0, 0, 1, 2, 1, 0, 2};
  localparam int vNum [NV]  = '{3, 0, 5, 4, 1, 0, 3};
  localparam int vSt [NV]   = '{3, 0, 0, 0, 3, 0, 1};
  localparam int vFail [NV] = '{0, 0, 0, 0, 0, 0, 2};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sendErrors(input int dimm, input int n);
    for (int i = 0; i < n; i++) begin
      errValid = 1'b1;
      errDimm  = IDX_W'(dimm);
      @(negedge clk);
    end
    errValid = 1'b0;
  endtask

  task automatic pulseDone();
    copyDone = 1'b1;
    @(negedge clk);
    copyDone = 1'b0;
  endtask

  task automatic doReset(input int thr);
    rstN      = 1'b0;
    threshold = CNT_W'(thr);
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(1);
  endtask

  initial begin
    waitCycles(200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 state", stateOut, 0);
    check("R1 copyReq", copyReq, 0);
    check("R1 inService", spareInService, 0);
    check("R1 retireMask", retireMask, 0);
    check("R1 failDimm", failDimm, 0);

    // table walk: R2 disable, R3 strict crossing, R8 counting while disabled, R9
    for (int v = 0; v < NV; v++) begin
      threshold = CNT_W'(vThr[v]);
      sendErrors(vDimm[v], vNum[v]);
      waitCycles(2);
      check($sformatf("R3 step%0d state", v), stateOut, vSt[v]);
      check($sformatf("R2 step%0d hidden", v), spareHidden, (vSt[v] == 0 || vSt[v] == 1) ? 1 : 0);
      if (vSt[v] == 1) check("R9 failDimm", failDimm, vFail[v]);
    end

    // R4 copy order and hold
    check("R4 copyReq", copyReq, 1);
    check("R4 first src", copySrc, 2);
    waitCycles(5);
    check("R4 src held", copySrc, 2);
    check("R4 still copying", stateOut, 1);
    pulseDone();
    check("R4 partner src", copySrc, 0);
    check("R4 still req", copyReq, 1);
    check("R5 no switch yet", spareInService, 0);
    pulseDone();
    // R5 switch
    check("R5 state", stateOut, 2);
    check("R5 copyReq", copyReq, 0);
    check("R5 inService", spareInService, 1);
    check("R5 retireMask", retireMask, 4'b0101);
    check("R9 failDimm spared", failDimm, 2);

    // R6 sticky
    threshold = 8'd1;
    sendErrors(3, 5);
    waitCycles(2);
    check("R6 state", stateOut, 2);
    check("R6 copyReq", copyReq, 0);
    check("R6 retireMask", retireMask, 4'b0101);
    threshold = 8'd0;
    waitCycles(2);
    check("R6 state thr0", stateOut, 2);

    // R7 lowest index wins
    doReset(20);
    sendErrors(3, 5);
    sendErrors(1, 5);
    waitCycles(2);
    check("R7 idle before", stateOut, 0);
    threshold = 8'd3;
    waitCycles(2);
    check("R7 state", stateOut, 1);
    check("R7 failDimm", failDimm, 1);
    check("R7 src", copySrc, 1);
    pulseDone();
    check("R7 partner", copySrc, 3);
    pulseDone();
    check("R7 retireMask", retireMask, 4'b1010);

    // R8 saturation
    doReset(255);
    sendErrors(0, 300);
    waitCycles(2);
    check("R8 no fire at max", stateOut, 0);
    threshold = 8'd200;
    waitCycles(2);
    check("R8 saturated tally fires", stateOut, 1);
    check("R8 failDimm", failDimm, 0);

    finishRun();
  end

endmodule